// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic core of a small byte-wide processor. It holds an accumulator and a hidden second-operand register, and on each executed operation it combines the two. It writes the result back to the accumulator and refreshes five status bits: sign, zero, half-carry, even parity and carry/borrow. Supported operations are addition and subtraction, each with or without carry, AND, OR, XOR, compare, and increment or decrement of the accumulator.

A second path increments or decrements a byte that arrives on the data input. That byte stands for some other register of the processor. The updated value is returned on a separate registered output, and the status bits are refreshed in the same way as for an accumulator increment or decrement. Load strobes write the accumulator or the hidden operand register directly from the data input. All outputs are registered, and results appear one clock after the command.

Top module: `acc_alu8`

## Requirements
- R1: While `rst` is high at a rising clock edge, `acc`, the hidden operand and `reg_result` become 0, and `flags` becomes 8'h02.
- R2: `acc_load` copies `data_in` into `acc`, and `tmp_load` copies `data_in` into the hidden operand. Neither changes `flags`. When `acc_load` and an accumulator-writing `exec` fall on the same edge, `acc_load` decides the accumulator value and `exec` still decides the flags. An `exec` always uses the operand value held before that edge.
- R3: With `exec` high, op 0 (add) sets `acc` to acc+operand and op 1 (add with carry) sets it to acc+operand+CY. CY becomes the carry out of bit 7.
- R4: Op 2 (subtract) sets `acc` to acc-operand and op 3 (subtract with borrow) sets it to acc-operand-CY. CY becomes 1 exactly when the subtrahend plus borrow exceeds the accumulator.
- R5: AC is the carry from bit 3 into bit 4 of the binary addition performed. Subtraction is performed as acc + ~operand + (1 minus borrow-in). Increment adds 1 and decrement adds 8'hFF.
- R6: After every executed operation, S equals bit 7 of the result. Z is 1 when the result is zero. P is 1 when the result holds an even number of ones.
- R7: Op 4 (AND), op 5 (OR) and op 6 (XOR) combine acc with the operand and clear CY. AC is set to 1 by AND and cleared by OR and XOR.
- R8: Op 7 (compare) sets all five flags exactly as op 2 would, and `acc` keeps its value.
- R9: Op 8 increments and op 9 decrements `acc` by one, modulo 256. S, Z, AC and P are updated, and CY keeps its value.
- R10: Op 10 sets `reg_result` to data_in+1 and op 11 sets it to data_in-1, modulo 256. S, Z, AC and P are updated from that result, while CY, `acc` and the operand register keep their values.
- R11: `flags` packs S, Z, AC, P and CY into bits 7, 6, 4, 2 and 0. Bit 1 is 1, and bits 3 and 5 are 0.
- R12: With `exec` low, or with op 12 to 15, `acc`, `flags` and `reg_result` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| exec | input | 1 | Execute the operation on `op` this cycle |
| op | input | 4 | Operation code |
| data_in | input | 8 | Byte for loads and for the register increment/decrement path |
| acc_load | input | 1 | Load `data_in` into the accumulator |
| tmp_load | input | 1 | Load `data_in` into the hidden operand register |
| acc | output | 8 | Accumulator value |
| flags | output | 8 | Status byte (S, Z, AC, P, CY plus fixed bits) |
| reg_result | output | 8 | Result of the register increment/decrement path |

## Verification
Fixed corner pairs are tried first. Adding 3A and C6 wraps to zero, which shows carry, half-carry, zero and parity all set together. Subtracting 01 from 00 shows borrow and sign, and a nibble-edge increment and decrement exercise AC on both the accumulator and the register path. A long random stream of every op code follows, including undefined codes, with loads falling in the same cycle as executes. It separates the carry-in use of ADC and SBB from plain ADD and SUB, and shows that the register path and compare leave the accumulator alone. It also covers the cases where a same-cycle operand load must not affect the running operation.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_ADC  = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_SBB  = 4'd3;
  localparam logic [3:0] OP_AND  = 4'd4;
  localparam logic [3:0] OP_OR   = 4'd5;
  localparam logic [3:0] OP_XOR  = 4'd6;
  localparam logic [3:0] OP_CMP  = 4'd7;
  localparam logic [3:0] OP_INC  = 4'd8;
  localparam logic [3:0] OP_DEC  = 4'd9;
  localparam logic [3:0] OP_XINC = 4'd10;
  localparam logic [3:0] OP_XDEC = 4'd11;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } status_t;
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         half_c,
  output logic         cout
);
  localparam int H  = W / 2;
  localparam int HW = W - H;

  logic [H:0]  lo;
  logic [HW:0] hi;

  always_comb begin
    lo = {1'b0, a[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, cin};
    hi = {1'b0, a[W-1:H]} + {1'b0, b[W-1:H]} + {{HW{1'b0}}, lo[H]};
  end

  assign sum    = {hi[HW-1:0], lo[H-1:0]};
  assign half_c = lo[H];
  assign cout   = hi[HW];
endmodule

// File: rtl/alu8_resflags.sv
module alu8_resflags #(
  parameter int W = 8
) (
  input  logic [W-1:0] res,
  output logic         sgn,
  output logic         zero,
  output logic         even
);
  assign sgn  = res[W-1];
  assign zero = (res == '0);
  assign even = ~^res;
endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] acc_v,
  input  logic [W-1:0] opnd_v,
  input  logic [W-1:0] ext_v,
  input  logic         cy_v,
  output logic [W-1:0] result,
  output status_t      nflags,
  output logic         wr_acc,
  output logic         wr_reg,
  output logic         upd
);
  logic [W-1:0] add_a, add_b, sum;
  logic         add_c, half_c, cout;
  logic         sgn, zero, even;

  alu8_adder #(.W(W)) u_add (
    .a(add_a), .b(add_b), .cin(add_c),
    .sum(sum), .half_c(half_c), .cout(cout)
  );

  alu8_resflags #(.W(W)) u_rf (
    .res(result), .sgn(sgn), .zero(zero), .even(even)
  );

  always_comb begin
    add_a = acc_v;
    add_b = opnd_v;
    add_c = 1'b0;
    unique case (op)
      OP_ADC:         add_c = cy_v;
      OP_SUB, OP_CMP: begin add_b = ~opnd_v; add_c = 1'b1;  end
      OP_SBB:         begin add_b = ~opnd_v; add_c = ~cy_v; end
      OP_INC:         begin add_b = '0; add_c = 1'b1; end
      OP_DEC:         add_b = '1;
      OP_XINC:        begin add_a = ext_v; add_b = '0; add_c = 1'b1; end
      OP_XDEC:        begin add_a = ext_v; add_b = '1; end
      default: ;
    endcase
  end

  always_comb begin
    result = sum;
    nflags.ac = half_c;
    nflags.cy = cy_v;
    unique case (op)
      OP_ADD, OP_ADC:         nflags.cy = cout;
      OP_SUB, OP_SBB, OP_CMP: nflags.cy = ~cout;
      OP_AND: begin result = acc_v & opnd_v; nflags.ac = 1'b1; nflags.cy = 1'b0; end
      OP_OR:  begin result = acc_v | opnd_v; nflags.ac = 1'b0; nflags.cy = 1'b0; end
      OP_XOR: begin result = acc_v ^ opnd_v; nflags.ac = 1'b0; nflags.cy = 1'b0; end
      default: ;
    endcase
    nflags.s = sgn;
    nflags.z = zero;
    nflags.p = even;
  end

  assign upd    = (op <= OP_XDEC);
  assign wr_reg = (op == OP_XINC) || (op == OP_XDEC);
  assign wr_acc = upd && !wr_reg && (op != OP_CMP);
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         exec,
  input  logic [3:0]   op,
  input  logic [W-1:0] data_in,
  input  logic         acc_load,
  input  logic         tmp_load,
  output logic [W-1:0] acc,
  output logic [7:0]   flags,
  output logic [W-1:0] reg_result
);
  logic [W-1:0] acc_q, opnd_q, reg_q, result;
  status_t      st_q, nflags;
  logic         wr_acc, wr_reg, upd;

  alu8_datapath #(.W(W)) u_dp (
    .op(op), .acc_v(acc_q), .opnd_v(opnd_q), .ext_v(data_in), .cy_v(st_q.cy),
    .result(result), .nflags(nflags), .wr_acc(wr_acc), .wr_reg(wr_reg), .upd(upd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      opnd_q <= '0;
      reg_q  <= '0;
      st_q   <= '0;
    end else begin
      if (tmp_load) opnd_q <= data_in;
      if (acc_load) acc_q <= data_in;
      else if (exec && wr_acc) acc_q <= result;
      if (exec && wr_reg) reg_q <= result;
      if (exec && upd) st_q <= nflags;
    end
  end

  assign acc        = acc_q;
  assign reg_result = reg_q;
  assign flags      = {st_q.s, st_q.z, 1'b0, st_q.ac, 1'b0, st_q.p, 1'b1, st_q.cy};

  // R8: compare leaves the accumulator alone
  a_r8_cmp_keeps_acc: assert property (@(posedge clk) disable iff (rst)
    (exec && op == OP_CMP && !acc_load) |=> $stable(acc));

  // R9 / R10: increment and decrement keep the carry bit
  a_r9_incdec_keeps_cy: assert property (@(posedge clk) disable iff (rst)
    (exec && op >= OP_INC && op <= OP_XDEC) |=> (flags[0] == $past(flags[0])));

  // R7: logic operations clear carry
  a_r7_logic_clears_cy: assert property (@(posedge clk) disable iff (rst)
    (exec && op >= OP_AND && op <= OP_XOR) |=> !flags[0]);

  // R6: zero flag agrees with the written accumulator
  a_r6_zero_matches_acc: assert property (@(posedge clk) disable iff (rst)
    (exec && wr_acc && !acc_load) |=> (flags[6] == (acc == '0)));

  // R6: parity flag agrees with the written accumulator
  a_r6_parity_matches_acc: assert property (@(posedge clk) disable iff (rst)
    (exec && wr_acc && !acc_load) |=> (flags[2] == ~^acc));

  // R12: idle cycles change nothing
  a_r12_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!exec && !acc_load) |=> ($stable(acc) && $stable(flags) && $stable(reg_result)));
endmodule

// File: tb/acc_alu8_tb_top.sv
`timescale 1ns/1ps
module acc_alu8_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       exec, acc_load, tmp_load;
  logic [3:0] op;
  logic [7:0] data_in;
  logic [7:0] acc, flags, reg_result;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  int m_acc, m_tmp, m_reg, m_s, m_z, m_ac, m_p, m_cy;

  always #4 clk = ~clk;

  acc_alu8 dut_i (
    .clk(clk), .rst(rst), .exec(exec), .op(op), .data_in(data_in),
    .acc_load(acc_load), .tmp_load(tmp_load),
    .acc(acc), .flags(flags), .reg_result(reg_result)
  );

  function automatic string req_of(input int o);
    case (o)
      0, 1:    return "R3";
      2, 3:    return "R4";
      4, 5, 6: return "R7";
      7:       return "R8";
      8, 9:    return "R9";
      10, 11:  return "R10";
      default: return "R12";
    endcase
  endfunction

  function automatic int ones(input int v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += (v >> i) & 1;
    return c;
  endfunction

  function automatic int flag_byte();
    return (m_s << 7) | (m_z << 6) | (m_ac << 4) | (m_p << 2) | 2 | m_cy;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic model(input int o, input int d, input bit ex, input bit la, input bit lt);
    int a, b, res, ac, cy, bb, cin, sum, lo;
    bit upd, wacc, wreg;
    a = m_acc; b = m_tmp; res = 0; ac = m_ac; cy = m_cy;
    upd = ex && (o <= 11);
    wacc = upd && (o <= 6 || o == 8 || o == 9);
    wreg = upd && (o == 10 || o == 11);
    if (upd) begin
      case (o)
        0, 1: begin
          cin = (o == 1) ? m_cy : 0;
          sum = a + b + cin;
          res = sum & 255; cy = (sum > 255);
          lo = (a & 15) + (b & 15) + cin; ac = (lo > 15);
        end
        2, 3, 7: begin
          cin = (o == 3) ? m_cy : 0;
          res = (a - b - cin) & 255; cy = (a < b + cin);
          bb = (~b) & 255;
          lo = (a & 15) + (bb & 15) + (1 - cin); ac = (lo > 15);
        end
        4: begin res = a & b; ac = 1; cy = 0; end
        5: begin res = a | b; ac = 0; cy = 0; end
        6: begin res = a ^ b; ac = 0; cy = 0; end
        8:  begin res = (a + 1) & 255; ac = ((a & 15) == 15); end
        9:  begin res = (a - 1) & 255; ac = ((a & 15) != 0); end
        10: begin res = (d + 1) & 255; ac = ((d & 15) == 15); end
        default: begin res = (d - 1) & 255; ac = ((d & 15) != 0); end
      endcase
      m_s = (res >> 7) & 1; m_z = (res == 0); m_p = (ones(res) % 2 == 0);
      m_ac = ac; m_cy = cy;
    end
    if (lt) m_tmp = d;
    if (la) m_acc = d;
    else if (wacc) m_acc = res;
    if (wreg) m_reg = res;
  endtask

  task automatic step(input int o, input int d, input bit ex, input bit la, input bit lt);
    string req;
    @(negedge clk);
    op = 4'(o); data_in = 8'(d); exec = ex; acc_load = la; tmp_load = lt;
    model(o, d, ex, la, lt);
    req = ex ? req_of(o) : (la || lt) ? "R2" : "R12";
    @(posedge clk);
    #2;
    check(req, "acc", acc, m_acc);
    check(req, "flags", flags, flag_byte());
    check(req, "reg_result", reg_result, m_reg);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8ns * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; exec = 0; acc_load = 0; tmp_load = 0; op = 0; data_in = 0;
    m_acc = 0; m_tmp = 0; m_reg = 0; m_s = 0; m_z = 0; m_ac = 0; m_p = 0; m_cy = 0;
    repeat (3) @(posedge clk);
    #2;
    check("R1", "acc", acc, 0);
    check("R1", "flags", flags, 8'h02);
    check("R1", "reg_result", reg_result, 0);
    @(negedge clk); rst = 1'b0;

    // R11 / R5 corner: 3A + C6 wraps to zero with every carry set
    step(0, 8'h3A, 0, 1, 0);
    step(0, 8'hC6, 0, 0, 1);
    step(0, 0, 1, 0, 0);
    check("R11", "flags add wrap", flags, 8'h57);
    check("R3", "acc add wrap", acc, 8'h00);
    // R4: 00 - 01 borrows
    step(0, 8'h01, 0, 0, 1);
    step(2, 0, 1, 0, 0);
    check("R4", "flags borrow", flags, 8'h87);
    check("R4", "acc borrow", acc, 8'hFF);
    // R10: register path at nibble edge, CY held at 1
    step(10, 8'h0F, 1, 0, 0);
    check("R10", "reg inc", reg_result, 8'h10);
    check("R10", "flags reg inc", flags, 8'h13);
    check("R10", "acc kept", acc, 8'hFF);
    // R8: compare keeps acc
    step(7, 0, 1, 0, 0);
    check("R8", "acc cmp", acc, 8'hFF);
    // R2: same-cycle load and exec
    step(0, 8'h05, 1, 1, 1);

    for (int i = 0; i < 3000; i++) begin
      int o = $urandom_range(0, 15);
      int d = $urandom_range(0, 255);
      bit ex = ($urandom_range(0, 9) != 0);
      bit la = ($urandom_range(0, 7) == 0);
      bit lt = ($urandom_range(0, 2) == 0);
      step(o, d, ex, la, lt);
    end
    finish_run();
  end
endmodule